// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator with Repeat Masks

This block watches the running calendar time (month, day of month, hour, minute and second, all in BCD) and raises an alarm when the time reaches a programmed value. Five alarm registers hold the target value for each field. The top bit of each of those registers is a repeat bit. Together the five repeat bits set which fields must agree, so the alarm can fire once a year, once a month, once a day, once an hour, once a minute or every second. The comparison is made only on the cycle that carries the one-second tick, so one matching second raises the alarm once.

A match sets a pending alarm flag. If the alarm enable is set, an active-low interrupt line is driven. A read strobe on the flags register returns the flag, clears it and releases the interrupt. The value read is the one held before the clear, so software sees the flag drop to 0 only on a later read. While the system runs from backup power, the interrupt needs a second enable as well. A power-up pulse clears both enables and leaves the pending flag set, so an alarm that happened during power-up can still be found by reading the flags.

Top module: `alarm_cmp`

## Requirements
- R1: After a synchronous active-low reset, all five alarm registers are zero, the pending flag is clear, `rd_af` is 0 and `irq_n` is 1.
- R2: A write with `wr_en` high stores `wr_data` in an alarm register. The address map is 0x6 for month, 0x5 for day of month, 0x4 for hour, 0x3 for minute and 0x2 for second. A write to any other address changes nothing. Bit 7 of each alarm register is its repeat bit. In the month register, bit 6 is the alarm enable and bit 5 is the backup alarm enable.
- R3: When the repeat code is 00000, the flag is set only on a tick where all five fields agree. Compared value bits are [4:0] for month, [5:0] for day and hour, and [6:0] for minute and second.
- R4: The repeat code lists the bit-7 values in the order month, day, hour, minute, second. A 1 drops that field from the comparison. The listed codes are 10000 (monthly), 11000 (daily), 11100 (hourly), 11110 (each minute) and 11111 (each second).
- R5: Any repeat code outside 00000, 10000, 11000, 11100, 11110 and 11111 makes every tick a match.
- R6: A matching time without the tick leaves the flag unchanged.
- R7: A `flags_rd` strobe loads `rd_af` with the flag as it was before the read, then clears the flag. A second read therefore returns 0.
- R8: Outside backup mode, `irq_n` is 0 exactly while the flag is set and the alarm enable is 1.
- R9: In backup mode, `irq_n` is 0 only while the flag, the alarm enable and the backup alarm enable are all set.
- R10: A `pwr_up` pulse clears both enable bits and wins over a write in the same cycle. It leaves the flag and all other register bits unchanged.
- R11: With every repeat bit 0 and a day-of-month alarm of 0, valid time values never set the flag.
- R12: When a read strobe and a matching tick fall in the same cycle, the read returns the old flag value and the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| flags_rd | input | 1 | One-cycle flags-register read strobe |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hour, BCD |
| cur_date | input | 8 | Current day of month, BCD |
| cur_mon | input | 8 | Current month, BCD |
| sec_tick | input | 1 | One-second tick pulse |
| on_backup | input | 1 | System is running from backup power |
| pwr_up | input | 1 | Power-up pulse |
| irq_n | output | 1 | Active-low alarm interrupt |
| rd_af | output | 1 | Alarm flag value returned by the last flags read |

## Verification
The properties assume that `sec_tick`, `flags_rd` and `pwr_up` are single-cycle pulses. They also assume the time fields hold still through the cycle that carries a tick, so a match decision depends only on one stable sample. The stimulus changes every input just after the falling clock edge and holds it for a full cycle. It changes the time fields only between ticks, and it keeps the time values inside valid BCD calendar ranges. The disabled-alarm case depends on that last point, since a day of 0 never appears.

// File: rtl/alm_pkg.sv
// Shared constants for the alarm comparator.
// Assumes five BCD calendar fields, each one byte wide, with field 0 = second
// and field 4 = month.
package alm_pkg;
    localparam int NF      = 5;     // number of compared fields
    localparam int DW      = 8;     // register and field width
    localparam int AW      = 4;     // address width
    localparam int BASE    = 2;     // address of the seconds alarm register
    localparam int RPT_BIT = 7;     // repeat bit position in each alarm register
    localparam int AFE_BIT = 6;     // alarm enable, month register
    localparam int ABE_BIT = 5;     // backup alarm enable, month register

    // value bits compared per field, index 0 = second .. 4 = month
    localparam logic [NF-1:0][DW-1:0] VALUE_MASK =
        {8'h1F, 8'h3F, 8'h3F, 8'h7F, 8'h7F};

    // enable bits stored in the month register
    localparam logic [DW-1:0] EN_MASK = DW'((1 << AFE_BIT) | (1 << ABE_BIT));
endpackage

// File: rtl/alm_regs.sv
// Alarm register bank: one byte per compared field, written through a simple
// strobe port. Assumes field i lives at address BASE+i. The power-up pulse
// clears the enable bits of the top field and takes priority over a write.
module alm_regs #(
    parameter int NF   = alm_pkg::NF,
    parameter int DW   = alm_pkg::DW,
    parameter int AW   = alm_pkg::AW,
    parameter int BASE = alm_pkg::BASE
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [DW-1:0]          wr_data,
    input  logic                   pwr_up,
    output logic [NF-1:0][DW-1:0]  alarm_q,
    output logic [NF-1:0]          rpt,
    output logic                   afe,
    output logic                   abe
);
    for (genvar i = 0; i < NF; i++) begin : g_fld
        localparam int              ADDR_I = BASE + i;
        localparam logic [DW-1:0]   CLR_I  = (i == NF-1) ? alm_pkg::EN_MASK : '0;
        logic [DW-1:0] nxt;

        // next value: write when addressed, then strip enables on power-up
        always_comb begin
            nxt = alarm_q[i];
            if (wr_en && (wr_addr == ADDR_I[AW-1:0]))
                nxt = wr_data;
            if (pwr_up)
                nxt = nxt & ~CLR_I;
        end

        // register the field
        always_ff @(posedge clk) begin
            if (!rst_n) alarm_q[i] <= '0;
            else        alarm_q[i] <= nxt;
        end

        assign rpt[i] = alarm_q[i][alm_pkg::RPT_BIT];
    end

    assign afe = alarm_q[NF-1][alm_pkg::AFE_BIT];
    assign abe = alarm_q[NF-1][alm_pkg::ABE_BIT];
endmodule

// File: rtl/alm_match.sv
// Masked field comparator. A field is ignored when its repeat bit is set.
// The repeat code is legal only when it is a run of ones from the top field
// down. Any other code ignores every field, so every tick matches.
module alm_match #(
    parameter int NF = alm_pkg::NF,
    parameter int DW = alm_pkg::DW
) (
    input  logic [NF-1:0][DW-1:0] alarm_q,
    input  logic [NF-1:0][DW-1:0] cur,
    input  logic [NF-1:0]         rpt,
    output logic                  hit
);
    logic [NF-2:0] chain;
    logic [NF-1:0] fld_ok;
    logic          code_ok;

    // legal code: a set bit implies the next higher bit is set
    for (genvar i = 0; i < NF-1; i++) begin : g_chain
        assign chain[i] = !rpt[i] || rpt[i+1];
    end
    assign code_ok = &chain;

    // per-field verdict: ignored, or the value bits agree
    for (genvar i = 0; i < NF; i++) begin : g_cmp
        localparam logic [DW-1:0] M = alm_pkg::VALUE_MASK[i];
        logic eq;
        assign eq        = ((alarm_q[i] ^ cur[i]) & M) == '0;
        assign fld_ok[i] = (code_ok ? rpt[i] : 1'b1) || eq;
    end

    assign hit = &fld_ok;
endmodule

// File: rtl/alm_flag.sv
// Pending alarm flag, read snapshot and interrupt line. Assumes the tick and
// the read strobe are single-cycle pulses. A match on a tick wins over a
// clear by a read in the same cycle.
module alm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hit,
    input  logic flags_rd,
    input  logic afe,
    input  logic abe,
    input  logic on_backup,
    output logic af_q,
    output logic rd_af_q,
    output logic irq_n
);
    // pending flag: set on a matching tick, cleared by a read
    always_ff @(posedge clk) begin
        if (!rst_n)            af_q <= 1'b0;
        else if (tick && hit)  af_q <= 1'b1;
        else if (flags_rd)     af_q <= 1'b0;
    end

    // read snapshot: the flag as it stood before this read
    always_ff @(posedge clk) begin
        if (!rst_n)        rd_af_q <= 1'b0;
        else if (flags_rd) rd_af_q <= af_q;
    end

    // interrupt line, gated by the enables for the current power mode
    assign irq_n = !(af_q && afe && (!on_backup || abe));
endmodule

// File: rtl/alarm_cmp.sv
// Top of the alarm comparator. Packs the live BCD time fields, stores the
// alarm registers, compares the fields on each tick and drives the flag and
// interrupt. Assumes the time fields are stable in the cycle of the tick.
module alarm_cmp #(
    parameter int DW = alm_pkg::DW,
    parameter int AW = alm_pkg::AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          flags_rd,
    input  logic [DW-1:0] cur_sec,
    input  logic [DW-1:0] cur_min,
    input  logic [DW-1:0] cur_hour,
    input  logic [DW-1:0] cur_date,
    input  logic [DW-1:0] cur_mon,
    input  logic          sec_tick,
    input  logic          on_backup,
    input  logic          pwr_up,
    output logic          irq_n,
    output logic          rd_af
);
    localparam int NF = alm_pkg::NF;

    logic [NF-1:0][DW-1:0] cur_pk;
    logic [NF-1:0][DW-1:0] alarm_q;
    logic [NF-1:0]         rpt;
    logic                  en_afe;
    logic                  en_abe;
    logic                  match_hit;
    logic                  af_live;

    // field order: index 0 = second .. index NF-1 = month
    assign cur_pk = {cur_mon, cur_date, cur_hour, cur_min, cur_sec};

    alm_regs #(.NF(NF), .DW(DW), .AW(AW), .BASE(alm_pkg::BASE)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwr_up  (pwr_up),
        .alarm_q (alarm_q),
        .rpt     (rpt),
        .afe     (en_afe),
        .abe     (en_abe)
    );

    alm_match #(.NF(NF), .DW(DW)) u_match (
        .alarm_q (alarm_q),
        .cur     (cur_pk),
        .rpt     (rpt),
        .hit     (match_hit)
    );

    alm_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (sec_tick),
        .hit       (match_hit),
        .flags_rd  (flags_rd),
        .afe       (en_afe),
        .abe       (en_abe),
        .on_backup (on_backup),
        .af_q      (af_live),
        .rd_af_q   (rd_af),
        .irq_n     (irq_n)
    );
endmodule

// File: rtl/alarm_cmp_chk.sv
// Property checker for alarm_cmp, attached with bind. Relates the compare
// result, flag state, enables and outputs across clock cycles.
module alarm_cmp_chk (
    input logic clk,
    input logic rst_n,
    input logic sec_tick,
    input logic flags_rd,
    input logic pwr_up,
    input logic on_backup,
    input logic match_hit,
    input logic af_live,
    input logic en_afe,
    input logic en_abe,
    input logic rd_af,
    input logic irq_n
);
    AST_IRQ_NEEDS_AFE: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (af_live && en_afe)); // R8

    AST_BACKUP_NEEDS_ABE: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && on_backup) |-> en_abe); // R9

    AST_PWRUP_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_up |=> (!en_afe && !en_abe)); // R10

    AST_FLAG_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_tick && !flags_rd) |=> (af_live == $past(af_live))); // R6

    AST_READ_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
        flags_rd |=> (rd_af == $past(af_live))); // R7

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_rd && !(sec_tick && match_hit)) |=> !af_live); // R7

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && match_hit) |=> af_live); // R12
endmodule

bind alarm_cmp alarm_cmp_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_tick  (sec_tick),
    .flags_rd  (flags_rd),
    .pwr_up    (pwr_up),
    .on_backup (on_backup),
    .match_hit (match_hit),
    .af_live   (af_live),
    .en_afe    (en_afe),
    .en_abe    (en_abe),
    .rd_af     (rd_af),
    .irq_n     (irq_n)
);

// File: tb/alarm_cmp_tb.sv
// Bench for alarm_cmp: a behavioural reference model updated at each rising
// edge, with the outputs compared shortly after every edge.
module alarm_cmp_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       flags_rd = 1'b0;
    logic [7:0] cur_sec = 8'h45, cur_min = 8'h30, cur_hour = 8'h10;
    logic [7:0] cur_date = 8'h25, cur_mon = 8'h12;
    logic       sec_tick = 1'b0;
    logic       on_backup = 1'b0;
    logic       pwr_up = 1'b0;
    logic       irq_n;
    logic       rd_af;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // reference state
    logic [7:0] m_reg [0:4];
    bit         m_af = 0;
    bit         m_rd = 0;

    always #5 clk = ~clk;

    alarm_cmp u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .flags_rd(flags_rd), .cur_sec(cur_sec),
        .cur_min(cur_min), .cur_hour(cur_hour), .cur_date(cur_date),
        .cur_mon(cur_mon), .sec_tick(sec_tick), .on_backup(on_backup),
        .pwr_up(pwr_up), .irq_n(irq_n), .rd_af(rd_af)
    );

    function automatic bit model_hit();
        logic [7:0] now [0:4];
        logic [4:0] code;
        int         n;
        bit         ok = 1;
        now[0] = cur_sec; now[1] = cur_min; now[2] = cur_hour;
        now[3] = cur_date; now[4] = cur_mon;
        code = {m_reg[4][7], m_reg[3][7], m_reg[2][7], m_reg[1][7], m_reg[0][7]};
        case (code)
            5'b00000: n = 5;
            5'b10000: n = 4;
            5'b11000: n = 3;
            5'b11100: n = 2;
            5'b11110: n = 1;
            default:  n = 0;
        endcase
        for (int k = 0; k < n; k++) begin
            logic [7:0] msk;
            msk = (k < 2) ? 8'h7F : (k < 4) ? 8'h3F : 8'h1F;
            if ((m_reg[k] & msk) != (now[k] & msk)) ok = 0;
        end
        return ok;
    endfunction

    // reference model update
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 5; k++) m_reg[k] = 8'h00;
            m_af = 0;
            m_rd = 0;
        end else begin
            bit h;
            h = model_hit();
            if (flags_rd) begin
                m_rd = m_af;
                m_af = 0;
            end
            if (sec_tick && h) m_af = 1;
            if (wr_en && wr_addr >= 4'h2 && wr_addr <= 4'h6)
                m_reg[wr_addr - 4'h2] = wr_data;
            if (pwr_up) m_reg[4] = m_reg[4] & 8'h9F;
        end
    end

    // compare outputs after each edge, plus the watchdog
    always @(posedge clk) begin
        #2;
        if (!done) begin
            bit exp_irq_n;
            cyc++;
            exp_irq_n = !(m_af && m_reg[4][6] && (!on_backup || m_reg[4][5]));
            n_cmp++;
            if (irq_n !== exp_irq_n || rd_af !== m_rd) begin
                n_bad++;
                $display("FAIL %s cycle %0d: irq_n=%b rd_af=%b expected irq_n=%b rd_af=%b",
                         cur_req, cyc, irq_n, rd_af, exp_irq_n, m_rd);
            end
            if (cyc > 20000) begin
                n_bad++;
                $display("FAIL watchdog: run did not finish, actual %0d cycles expected under 20000", cyc);
                done = 1'b1;
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
    endtask

    task automatic do_rd();
        @(negedge clk); flags_rd = 1'b1;
        @(negedge clk); flags_rd = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] mo, d, h, mi, s);
        @(negedge clk);
        cur_mon = mo; cur_date = d; cur_hour = h; cur_min = mi; cur_sec = s;
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        idle(2);

        // R2: load alarm 12/25 10:30:45, enable on; stray addresses ignored
        cur_req = "R2";
        do_wr(4'h2, 8'h45);
        do_wr(4'h3, 8'h30);
        do_wr(4'h4, 8'h10);
        do_wr(4'h5, 8'h25);
        do_wr(4'h6, 8'h52);
        do_wr(4'h7, 8'hFF);
        do_wr(4'h1, 8'hFF);
        do_wr(4'h0, 8'hFF);
        idle(2);

        // R3: full match needs every field
        cur_req = "R3";
        set_time(8'h12, 8'h25, 8'h10, 8'h30, 8'h46); do_tick();
        set_time(8'h11, 8'h25, 8'h10, 8'h30, 8'h45); do_tick();
        set_time(8'h12, 8'h25, 8'h10, 8'h30, 8'h45); do_tick();
        idle(2);

        // R7: first read returns 1, second returns 0
        cur_req = "R7";
        do_rd(); idle(1); do_rd(); idle(2);

        // R6: matching time with no tick leaves the flag clear
        cur_req = "R6";
        idle(5); do_rd(); idle(1);

        // R4: hourly code 11100 ignores month, day and hour
        cur_req = "R4";
        do_wr(4'h6, 8'hD2);
        do_wr(4'h5, 8'hA5);
        do_wr(4'h4, 8'h90);
        set_time(8'h01, 8'h01, 8'h03, 8'h30, 8'h45); do_tick();
        do_rd(); idle(1);
        set_time(8'h01, 8'h01, 8'h03, 8'h31, 8'h45); do_tick();
        do_rd(); idle(1);
        do_wr(4'h3, 8'hB0);           // code 11110: each minute
        do_tick();
        do_rd(); idle(1);
        set_time(8'h01, 8'h01, 8'h03, 8'h31, 8'h44); do_tick();
        do_rd(); idle(1);

        // R5: unlisted code 10100 matches every tick
        cur_req = "R5";
        do_wr(4'h3, 8'h30);
        do_wr(4'h5, 8'h25);           // rpt bits now 1,0,1,0,0
        set_time(8'h07, 8'h19, 8'h22, 8'h05, 8'h11); do_tick();
        idle(2);

        // R8: interrupt follows the alarm enable
        cur_req = "R8";
        do_wr(4'h6, 8'h92);           // enable off, repeat bit kept
        idle(2);
        do_wr(4'h6, 8'hD2);
        idle(2);

        // R9: backup mode needs the backup enable as well
        cur_req = "R9";
        @(negedge clk); on_backup = 1'b1;
        idle(2);
        do_wr(4'h6, 8'hF2);
        idle(2);
        @(negedge clk); on_backup = 1'b0;
        do_rd(); idle(1);

        // R10: power-up clears both enables, keeps the flag
        cur_req = "R10";
        @(negedge clk); on_backup = 1'b1;
        do_tick();
        idle(1);
        @(negedge clk); pwr_up = 1'b1; wr_en = 1'b1; wr_addr = 4'h6; wr_data = 8'hF2;
        @(negedge clk); pwr_up = 1'b0; wr_en = 1'b0;
        idle(2);
        @(negedge clk); on_backup = 1'b0;
        idle(1);
        do_rd(); idle(1);
        do_tick(); idle(1);
        do_rd(); idle(1);

        // R11: day 0 with all repeat bits clear never matches
        cur_req = "R11";
        do_wr(4'h2, 8'h45);
        do_wr(4'h3, 8'h30);
        do_wr(4'h4, 8'h10);
        do_wr(4'h5, 8'h00);
        do_wr(4'h6, 8'h52);
        set_time(8'h12, 8'h25, 8'h10, 8'h30, 8'h45);
        do_tick(); do_tick(); do_tick();
        do_rd(); idle(2);

        // R12: read and matching tick together keep the flag set
        cur_req = "R12";
        do_wr(4'h2, 8'hC5);
        do_wr(4'h3, 8'hB0);
        do_wr(4'h4, 8'h90);
        do_wr(4'h5, 8'h80);
        do_wr(4'h6, 8'hD2);           // code 11111
        do_tick(); idle(1);
        @(negedge clk); flags_rd = 1'b1; sec_tick = 1'b1;
        @(negedge clk); flags_rd = 1'b0; sec_tick = 1'b0;
        idle(1);
        do_rd(); idle(1);
        do_rd(); idle(2);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule